// File: doc/BRIEF.md
# Toggle-Request Falling-Edge RAM Port

This block is a single-port word memory placed beside the data-path of a generated state machine. The data-path never reaches into the storage array. It places an address on the port, plus write data and a store select for a write, and then inverts a one-bit request line. The port keeps its own copy of the request level it last served. On every falling clock edge it compares that copy with the live request line. When the two differ it performs exactly one load or one store and then takes the live level as its new copy. The port therefore switches itself off after each access, and the data-path never has to clear an enable.

Because the access happens on the falling edge, a store finishes inside the data-path's own cycle. A load places the addressed word in the read-data register half a cycle after the request, and the data-path can capture it at the next rising edge. All reads and writes of the array sit in one process, so the array can map onto a RAM block. The request, address and data lines are plain control and data pins with no valid/ready handshake. The toggle protocol takes the place of back-pressure: the port serves any request in the cycle it arrives, and the data-path may change the request line at most once per cycle.

Top module: `tgl_ram`

## Requirements
- R1: While reset is asserted for at least one falling edge, the read-data output becomes zero and the served-request copy is cleared. After reset is released with the request line held low, no access takes place.
- R2: A load starts when the request line changes level with store select low (0 = load). The word at the given address appears on the read-data output after the falling edge of that same cycle.
- R3: A store starts when the request line changes level with store select high (1 = store). The write data is stored at the given address on the falling edge of that same cycle, and the read-data output does not change.
- R4: While the request line keeps its level, changes on store select, address or write data have no effect on the array or on the read-data output.
- R5: A rising and a falling change of the request line each start an access in the same way.
- R6: A load of an address issued in the cycle right after a store to that address returns the newly written word.
- R7: Each change of the request line causes exactly one access. If the line then holds its level, a later change of the address does not alter the read-data output.
- R8: The lowest address (0) and the highest address (DEPTH-1) hold independent words.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. Accesses take place on its falling edge |
| rst_n | input | 1 | Active-low reset, sampled on the falling edge |
| req_tgl | input | 1 | Request line. Any change of level requests one access |
| wr_en | input | 1 | Store select: 1 = store, 0 = load |
| addr | input | $clog2(DEPTH) | Word address |
| wdata | input | DW | Word to store |
| rdata | output | DW | Read-data register. Holds the word of the last load |

## Verification
Two functions can meet in neighbouring falling edges: a store, and a load of the same address in the very next cycle. A load can also fall in a cycle where the request line is idle while the other inputs keep moving. The bench provokes the first case by issuing a store and then, one cycle later, a load to the same word, and judges it by whether the new word comes back. It provokes the second by changing address, data and store select with the request line held, and then reading back to confirm that nothing was written and that the read-data output did not move.

// File: rtl/tgl_ram_pkg.sv
package tgl_ram_pkg;
  localparam int unsigned DW_DEF    = 32;
  localparam int unsigned DEPTH_DEF = 256;

  typedef enum logic {
    OP_LOAD  = 1'b0,
    OP_STORE = 1'b1
  } op_kind_e;
endpackage

// File: rtl/tgl_ram_detect.sv
module tgl_ram_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic req_tgl,
  output logic fire
);
  logic seen_q;

  assign fire = req_tgl ^ seen_q;

  always_ff @(negedge clk) begin
    if (!rst_n)    seen_q <= 1'b0;
    else if (fire) seen_q <= req_tgl;
  end

  // R7: after an access the served copy matches the request that was served
  p_copy_follows_r7: assert property (@(negedge clk) disable iff (!rst_n)
    fire |=> (seen_q == $past(req_tgl)));

  // R7: a held request line never fires twice
  p_single_shot_r7: assert property (@(negedge clk) disable iff (!rst_n)
    ($past(fire) && $stable(req_tgl)) |-> !fire);
endmodule

// File: rtl/tgl_ram_store.sv
module tgl_ram_store
  import tgl_ram_pkg::*;
#(
  parameter int unsigned DW    = DW_DEF,
  parameter int unsigned DEPTH = DEPTH_DEF,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem_q [DEPTH];
  op_kind_e      kind;

  assign kind = op_kind_e'(wr_en);

  // single process: every array read and write lives here
  always_ff @(negedge clk) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (fire) begin
      if (kind == OP_STORE) mem_q[addr] <= wdata;
      else                  rdata       <= mem_q[addr];
    end
  end

  // R4: no request, no movement on the read-data output
  p_idle_hold_r4: assert property (@(negedge clk) disable iff (!rst_n)
    !fire |=> $stable(rdata));

  // R3: a store leaves the read-data output untouched
  p_store_keeps_r3: assert property (@(negedge clk) disable iff (!rst_n)
    (fire && wr_en) |=> $stable(rdata));
endmodule

// File: rtl/tgl_ram.sv
module tgl_ram
  import tgl_ram_pkg::*;
#(
  parameter int unsigned DW    = DW_DEF,
  parameter int unsigned DEPTH = DEPTH_DEF,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_tgl,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  logic fire;

  tgl_ram_detect u_detect (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_tgl (req_tgl),
    .fire    (fire)
  );

  tgl_ram_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (fire),
    .wr_en (wr_en),
    .addr  (addr),
    .wdata (wdata),
    .rdata (rdata)
  );
endmodule

// File: tb/tgl_ram_tb.sv
`timescale 1ns/1ps
module tgl_ram_tb;
  localparam int DW = 32;
  localparam int DEPTH = 256;
  localparam int AW = $clog2(DEPTH);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_tgl = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [DW-1:0] mem_m [DEPTH];
  logic [DW-1:0] mdl_rd = '0;
  logic [DW-1:0] exp_q [$];
  string         tag_q [$];

  tgl_ram #(.DW(DW), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_tgl(req_tgl), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  always #2.5 clk = ~clk;

  task automatic check(input string tag, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: rdata=%h expected=%h", tag, got, exp);
    end
  endtask

  // driver: one access per cycle, toggling the request line
  task automatic op(input bit we, input int a, input logic [DW-1:0] d, input string tag);
    @(posedge clk); #1;
    wr_en = we; addr = AW'(a); wdata = d; req_tgl = ~req_tgl;
    if (we) mem_m[a] = d;
    else    mdl_rd   = mem_m[a];
    exp_q.push_back(mdl_rd);
    tag_q.push_back(tag);
  endtask

  // driver: inputs move but the request line holds
  task automatic idle(input bit we, input int a, input logic [DW-1:0] d, input string tag);
    @(posedge clk); #1;
    wr_en = we; addr = AW'(a); wdata = d;
    exp_q.push_back(mdl_rd);
    tag_q.push_back(tag);
  endtask

  // monitor: after each falling edge compare against the oldest expectation
  initial begin
    forever begin
      @(negedge clk); #1.5;
      if (exp_q.size() > 0) begin
        logic [DW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, rdata, e);
      end
    end
  end

  initial begin
    #100000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: rdata=%h expected=completion", rdata);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1;
    check("R1 reset", rdata, '0);
    rst_n = 1'b1;
    idle(0, 3, 32'h0, "R1 no spurious access");
    idle(1, 4, 32'h1234, "R1 no spurious access");
    // store / load, both toggle directions
    op(1, 8'h10, 32'hA5A5_0001, "R3 store keeps rdata");
    op(1, 8'h20, 32'h5A5A_0002, "R5 falling toggle store");
    op(0, 8'h10, 32'h0, "R2 load");
    op(0, 8'h20, 32'h0, "R5 falling toggle load");
    // store then load same word next cycle
    op(1, 8'h10, 32'hCAFE_F00D, "R3 store keeps rdata");
    op(0, 8'h10, 32'h0, "R6 load after store");
    // inputs move while request holds
    idle(1, 8'h10, 32'hDEAD_BEEF, "R4 idle write ignored");
    idle(1, 8'h20, 32'hBAD0_BAD0, "R4 idle write ignored");
    op(0, 8'h10, 32'h0, "R4 word unchanged");
    op(0, 8'h20, 32'h0, "R4 word unchanged");
    // single access per toggle
    op(0, 8'h10, 32'h0, "R7 load");
    idle(0, 8'h20, 32'h0, "R7 no repeat on address change");
    idle(0, 8'h30, 32'h0, "R7 no repeat on address change");
    // address extremes
    op(1, 0, 32'h0000_1111, "R8 store low");
    op(1, DEPTH-1, 32'hFFFF_2222, "R8 store high");
    op(0, 0, 32'h0, "R8 load low");
    op(0, DEPTH-1, 32'h0, "R8 load high");
    // mixed pattern
    for (int i = 0; i < 16; i++)
      op(1, (i * 37 + 5) % DEPTH, 32'h1000_0000 + i * 32'h0101_0101, "R3 pattern store");
    for (int i = 15; i >= 0; i--)
      op(0, (i * 37 + 5) % DEPTH, 32'h0, "R2 pattern load");
    for (int i = 0; i < 8; i++) begin
      op(1, i * 3, 32'h7700_0000 + i, "R6 pattern store");
      op(0, i * 3, 32'h0, "R6 pattern load");
    end
    repeat (4) @(posedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule